// File: doc/BRIEF.md
# Output Port with Clock-Out and Buzzer Functions

This block is a four-pin general output port. In its plain form each pin simply drives the level of one bit of a data register. The two lowest pins can be given a second function when the block is built. Pin 0 can carry a divided copy of the system clock or the inverted half of a buzzer tone. Pin 1 can carry the buzzer tone itself. When both buzzer functions are chosen, pins 0 and 1 form a complementary pair that can drive a piezo element directly. The data bits still act as on/off gates for the special signals.

A control register holds a two-bit clock-out code and a buzzer-rate bit. All the special frequencies come from one free-running counter on the system clock. A build-time divider set fixes four clock-out rates, and the run-time code picks one of them. Any change of gate, code or buzzer rate waits for a counter boundary at which every affected tone starts a fresh low phase. Because of this, no shortened high pulse ever reaches a pin.

Top module: `oport_special`

## Requirements
- R1: After a synchronous reset, the data register, the control register and all four pins read 0.
- R2: A write to the data register is visible on `dat_rdata` one cycle later. Every pin in plain mode (pins 2 and 3 always) then drives its data bit, with 1 meaning high.
- R3: On a control write, bits [1:0] store the clock-out code and bit 3 stores the buzzer-rate bit. Bit 2 is discarded and always reads back as 0.
- R4: In clock-out mode, pin 0 carries the selected clock while the gate is 1 and is low while the gate is 0. Data bit 0 is the gate. For a divide ratio of 2^n, the clock is high exactly when (count mod 2^n) >= 2^(n-1). Here count is the free-running counter, which is 0 in the first cycle after reset and increases by one per cycle modulo 128.
- R5: For divider set k (1..5) and code c (0..3), the clock-out ratio is 2^(8-k-c). Code 0 is the slowest rate, and each higher code doubles the frequency.
- R6: When the ratio is 1 (set 5, code 3), pin 0 follows the system clock while the gate is on: high in the high half of each cycle and low in the low half.
- R7: In buzzer mode, pin 1 is the buzzer tone gated by data bit 1. Pin 0 is the inverted tone gated by data bit 0, and a gate of 0 gives a low level. Buzzer-rate bit 1 selects ratio 16 and bit 0 selects ratio 8, with the same phase rule as R4.
- R8: Clock-out gate and code changes take effect only at the clock edge where the counter wraps from 127 to 0.
- R9: Buzzer gate and rate changes take effect only at the clock edge where the low four counter bits wrap from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (fosc) |
| rst | input | 1 | Synchronous active-high reset |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 4 | Data register write value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write value: [1:0] code, [2] ignored, [3] buzzer rate |
| dat_rdata | output | 4 | Data register readback |
| ctl_rdata | output | 4 | Control register readback, bit 2 reads 0 |
| port_pins | output | 4 | Output pin levels |

## Verification
The bench builds three instances with different pin functions: divider set 1, divider set 5, and complementary buzzer. Each one is compared every half cycle against a behavioural model. Several patterns are applied, and each tells a different fault apart:
- Stepping the clock-out code through all four values separates the rate table from phase errors.
- Toggling the gate in mid-frame shows whether changes wait for the counter wrap.
- Alternating the buzzer rate and gates separates the tone pair from its gating.
- Writes with control bit 2 set, and level patterns on the plain pins, exercise the register side.

// File: rtl/oport_pkg.sv
package oport_pkg;

    localparam int PORT_W  = 4;
    localparam int CTL_W   = 4;
    localparam int CNT_W   = 7;
    localparam int BZ_LO   = 2;   // counter bit giving ratio 8
    localparam int BZ_HI   = 3;   // counter bit giving ratio 16
    localparam int BZ_SPAN = 4;   // buzzer boundary every 2^BZ_SPAN cycles

    typedef enum logic [1:0] {
        P0_LEVEL    = 2'd0,
        P0_CLKOUT   = 2'd1,
        P0_TONE_INV = 2'd2
    } pin0_fn_e;

    typedef enum logic {
        P1_LEVEL = 1'b0,
        P1_TONE  = 1'b1
    } pin1_fn_e;

    typedef struct packed {
        logic       bz_slow;
        logic [1:0] fsel;
    } ctl_t;

    // log2 of the clock-out divide ratio for build set k and run-time code c
    function automatic int clk_shift(input int set_k, input logic [1:0] code);
        return CNT_W + 1 - set_k - int'(code);
    endfunction

endpackage

// File: rtl/oport_regs.sv
module oport_regs
    import oport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_we,
    input  logic [PORT_W-1:0] dat_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [PORT_W-1:0] dat_q,
    output ctl_t              ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q <= '0;
            ctl_q <= '0;
        end else begin
            if (dat_we) dat_q <= dat_wdata;
            if (ctl_we) begin
                ctl_q.fsel    <= ctl_wdata[1:0];
                ctl_q.bz_slow <= ctl_wdata[3];
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dat_q == '0 && ctl_q == '0));

    a_r2_data_write: assert property (@(posedge clk) disable iff (rst)
        dat_we |=> dat_q == $past(dat_wdata));

    a_r3_ctl_write: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_q.fsel == $past(ctl_wdata[1:0]) &&
                    ctl_q.bz_slow == $past(ctl_wdata[3])));

endmodule

// File: rtl/oport_divider.sv
module oport_divider
    import oport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_end,
    output logic             seg_end
);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign frame_end = &cnt;
    assign seg_end   = &cnt[BZ_SPAN-1:0];

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (cnt == '0 && !seg_end));

    a_r9_seg_period: assert property (@(posedge clk) disable iff (rst)
        seg_end |=> !seg_end);

endmodule

// File: rtl/oport_clkout.sv
module oport_clkout
    import oport_pkg::*;
#(
    parameter int DIV_SET = 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             frame_end,
    input  logic             req_on,
    input  logic [1:0]       req_sel,
    output logic             pin
);

    localparam bit HAS_FAST = (clk_shift(DIV_SET, 2'd3) == 0);

    logic       on_eff;
    logic [1:0] sel_eff;
    logic       tone_reg;
    logic       pin_reg;
    int         n_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_eff  <= 1'b0;
            sel_eff <= 2'd0;
        end else if (frame_end) begin
            on_eff  <= req_on;
            sel_eff <= req_sel;
        end
    end

    assign n_eff = clk_shift(DIV_SET, sel_eff);

    always_comb begin
        tone_reg = 1'b0;
        for (int b = 0; b < CNT_W; b++) begin
            if (n_eff == b + 1) tone_reg = cnt[b];
        end
    end

    assign pin_reg = on_eff & tone_reg;

    generate
        if (HAS_FAST) begin : g_fast
            logic fast_en;
            // enable captured while the clock is low, like a gating cell
            always_ff @(negedge clk) begin
                if (rst) fast_en <= 1'b0;
                else     fast_en <= on_eff && (n_eff == 0);
            end
            assign pin = pin_reg | (clk & fast_en);
        end else begin : g_slow
            assign pin = pin_reg;
        end
    endgenerate

    a_r8_hold_mid_frame: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(on_eff) && $stable(sel_eff)));

    a_r8_wrap_starts_low: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !pin_reg);

endmodule

// File: rtl/oport_buzzer.sv
module oport_buzzer
    import oport_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tone_fast,
    input  logic tone_slow,
    input  logic seg_end,
    input  logic req_g0,
    input  logic req_g1,
    input  logic req_slow,
    output logic pin_inv,
    output logic pin_tone
);

    logic g0, g1, slow;
    logic tone;

    always_ff @(posedge clk) begin
        if (rst) begin
            g0   <= 1'b0;
            g1   <= 1'b0;
            slow <= 1'b0;
        end else if (seg_end) begin
            g0   <= req_g0;
            g1   <= req_g1;
            slow <= req_slow;
        end
    end

    assign tone     = slow ? tone_slow : tone_fast;
    assign pin_tone = g1 & tone;
    assign pin_inv  = g0 & ~tone;

    a_r9_hold_mid_seg: assert property (@(posedge clk) disable iff (rst)
        !seg_end |=> ($stable(g0) && $stable(g1) && $stable(slow)));

    a_r7_complement: assert property (@(posedge clk) disable iff (rst)
        (g0 && g1) |-> (pin_inv != pin_tone));

endmodule

// File: rtl/oport_special.sv
module oport_special
    import oport_pkg::*;
#(
    parameter pin0_fn_e PIN0_FN = P0_CLKOUT,
    parameter pin1_fn_e PIN1_FN = P1_TONE,
    parameter int       DIV_SET = 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_we,
    input  logic [PORT_W-1:0] dat_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [PORT_W-1:0] dat_rdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic [PORT_W-1:0] port_pins
);

    logic [PORT_W-1:0] dat_q;
    ctl_t              ctl_q;
    logic [CNT_W-1:0]  cnt;
    logic              frame_end, seg_end;
    logic              bz_inv, bz_tone;
    logic              co_pin;
    logic              unused_bits;

    initial begin
        assert (DIV_SET >= 1 && DIV_SET <= 5);
    end

    oport_regs u_regs (
        .clk(clk), .rst(rst),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_q(dat_q), .ctl_q(ctl_q)
    );

    oport_divider u_div (
        .clk(clk), .rst(rst),
        .cnt(cnt), .frame_end(frame_end), .seg_end(seg_end)
    );

    generate
        if (PIN0_FN == P0_CLKOUT) begin : g_co
            oport_clkout #(.DIV_SET(DIV_SET)) u_co (
                .clk(clk), .rst(rst), .cnt(cnt), .frame_end(frame_end),
                .req_on(dat_q[0]), .req_sel(ctl_q.fsel), .pin(co_pin)
            );
        end else begin : g_no_co
            assign co_pin = 1'b0;
        end

        if (PIN0_FN == P0_TONE_INV || PIN1_FN == P1_TONE) begin : g_bz
            oport_buzzer u_bz (
                .clk(clk), .rst(rst),
                .tone_fast(cnt[BZ_LO]), .tone_slow(cnt[BZ_HI]),
                .seg_end(seg_end),
                .req_g0(dat_q[0]), .req_g1(dat_q[1]), .req_slow(ctl_q.bz_slow),
                .pin_inv(bz_inv), .pin_tone(bz_tone)
            );
        end else begin : g_no_bz
            assign bz_inv  = 1'b0;
            assign bz_tone = 1'b0;
        end

        if (PIN0_FN == P0_CLKOUT) begin : g_p0c
            assign port_pins[0] = co_pin;
        end else if (PIN0_FN == P0_TONE_INV) begin : g_p0b
            assign port_pins[0] = bz_inv;
        end else begin : g_p0l
            assign port_pins[0] = dat_q[0];
        end

        if (PIN1_FN == P1_TONE) begin : g_p1b
            assign port_pins[1] = bz_tone;
        end else begin : g_p1l
            assign port_pins[1] = dat_q[1];
        end
    endgenerate

    assign port_pins[PORT_W-1:2] = dat_q[PORT_W-1:2];
    assign dat_rdata = dat_q;
    assign ctl_rdata = {ctl_q.bz_slow, 1'b0, ctl_q.fsel};
    assign unused_bits = ^{cnt, frame_end, seg_end, bz_inv, bz_tone, co_pin, ctl_q};

    a_r2_plain_high_pins: assert property (@(posedge clk) disable iff (rst)
        port_pins[PORT_W-1:2] == dat_rdata[PORT_W-1:2]);

endmodule

// File: tb/tb_oport_special.sv
module tb_oport_special;
    import oport_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dat_we = 1'b0;
    logic [3:0] dat_wdata = 4'd0;
    logic       ctl_we = 1'b0;
    logic [3:0] ctl_wdata = 4'd0;

    logic [3:0] a_dat, a_ctl, a_pins;
    logic [3:0] b_dat, b_ctl, b_pins;
    logic [3:0] c_dat, c_ctl, c_pins;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    // set 1 clock-out on pin 0, buzzer on pin 1
    oport_special #(.PIN0_FN(P0_CLKOUT), .PIN1_FN(P1_TONE), .DIV_SET(1)) dut (
        .clk(clk), .rst(rst), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_rdata(a_dat), .ctl_rdata(a_ctl), .port_pins(a_pins));

    // set 5 clock-out on pin 0, plain pin 1
    oport_special #(.PIN0_FN(P0_CLKOUT), .PIN1_FN(P1_LEVEL), .DIV_SET(5)) dut_s5 (
        .clk(clk), .rst(rst), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_rdata(b_dat), .ctl_rdata(b_ctl), .port_pins(b_pins));

    // complementary buzzer pair
    oport_special #(.PIN0_FN(P0_TONE_INV), .PIN1_FN(P1_TONE), .DIV_SET(3)) dut_bz (
        .clk(clk), .rst(rst), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_rdata(c_dat), .ctl_rdata(c_ctl), .port_pins(c_pins));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    function automatic bit tone(input int cnt, input int n);
        if (n <= 0) return 1'b0;
        return (cnt % (1 << n)) >= (1 << (n - 1));
    endfunction

    // behavioural model state
    int   m_cnt = 0;
    logic [3:0] m_dat = 4'd0;
    logic [1:0] m_fsel = 2'd0;
    bit   m_slow = 0;
    bit   c1_on = 0, c5_on = 0, c5_fast = 0;
    int   c1_sel = 0, c5_sel = 0;
    bit   bg0 = 0, bg1 = 0, bslow = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_dat = 0; m_fsel = 0; m_slow = 0;
            c1_on = 0; c5_on = 0; c1_sel = 0; c5_sel = 0;
            bg0 = 0; bg1 = 0; bslow = 0;
        end else begin
            if (m_cnt == 127) begin
                c1_on = m_dat[0]; c1_sel = m_fsel;
                c5_on = m_dat[0]; c5_sel = m_fsel;
            end
            if (m_cnt % 16 == 15) begin
                bg0 = m_dat[0]; bg1 = m_dat[1]; bslow = m_slow;
            end
            if (dat_we) m_dat = dat_wdata;
            if (ctl_we) begin m_fsel = ctl_wdata[1:0]; m_slow = ctl_wdata[3]; end
            m_cnt = (m_cnt + 1) % 128;
        end
        #2;
        check_pins(1'b1);
        #3;
        c5_fast = rst ? 1'b0 : (c5_on && (8 - 5 - c5_sel) == 0);
        #2;
        check_pins(1'b0);
    end

    task automatic check_pins(input bit hi_phase);
        int  bn = bslow ? 4 : 3;
        bit  bt = tone(m_cnt, bn);
        bit  e1 = c1_on && tone(m_cnt, 8 - 1 - c1_sel);
        bit  e5 = (c5_on && tone(m_cnt, 8 - 5 - c5_sel)) || (hi_phase && c5_fast);
        // R4 R5 R8 set-1 clock-out, R7 R9 buzzer on pin 1, R2 plain pins
        chk("R4 R5 R7 R8 R9 R2 dut pins", a_pins, {m_dat[3:2], bg1 & bt, e1});
        // R5 R6 R8 set-5 clock-out, R2 plain pin 1
        chk("R5 R6 R8 R2 dut_s5 pins", b_pins, {m_dat[3:1], e5});
        // R7 R9 complementary buzzer pair
        chk("R7 R9 dut_bz pins", c_pins, {m_dat[3:2], bg1 & bt, bg0 & ~bt});
        if (hi_phase) begin
            chk("R2 data readback", a_dat, m_dat);
            chk("R3 control readback", a_ctl, {m_slow, 1'b0, m_fsel});
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #3; end
    endtask

    task automatic wr_dat(input logic [3:0] v);
        dat_we = 1'b1; dat_wdata = v; cyc(1); dat_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        ctl_we = 1'b1; ctl_wdata = v; cyc(1); ctl_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        cyc(4);
        // R1: reset state
        chk("R1 data reg", a_dat, 4'd0);
        chk("R1 control reg", a_ctl, 4'd0);
        chk("R1 pins", a_pins | b_pins | c_pins, 4'd0);
        rst = 1'b0;
        cyc(3);
        // R2: plain levels
        wr_dat(4'b1100);
        cyc(1);
        chk("R2 readback after write", b_dat, 4'b1100);
        chk("R2 plain pins", b_pins, 4'b1100);
        // R3: bit 2 dropped
        wr_ctl(4'b0100);
        cyc(1);
        chk("R3 unused bit reads 0", a_ctl, 4'b0000);
        wr_ctl(4'b1111);
        cyc(1);
        chk("R3 full write readback", a_ctl, 4'b1011);
        wr_ctl(4'b0000);
        // R4 R5: clock-out at every code
        wr_dat(4'b0101);
        cyc(300);
        for (int c = 1; c < 4; c++) begin
            wr_ctl(4'(c));
            cyc(300);
        end
        // R8: gate off and on in mid frame
        cyc(40);
        wr_dat(4'b0100);
        cyc(60);
        wr_dat(4'b0001);
        cyc(200);
        wr_ctl(4'b0010);
        cyc(150);
        // R7 R9: buzzer pair, both rates and gate patterns
        wr_dat(4'b0011);
        wr_ctl(4'b0000);
        cyc(100);
        wr_ctl(4'b1000);
        cyc(100);
        wr_dat(4'b0010);
        cyc(70);
        wr_dat(4'b1001);
        cyc(70);
        wr_ctl(4'b0011);
        wr_dat(4'b0000);
        cyc(200);
        wr_dat(4'b1011);
        cyc(300);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule